// File: doc/BRIEF.md
# Four-and-a-half decade event counter

This block counts falling edges on a single event input and keeps the total as four binary-coded decimal digits plus an overflow half-digit. The largest value it can show is 19999. The event input is asynchronous. It is brought into the system clock domain by a synchronizer, and each falling edge found there advances the count by one. The input must therefore change more slowly than half the system clock rate.

When the four decades roll over from 9999 to 0000, the block sets the half-digit and pulses an active-low carry output. That carry output can drive the event input of a further block, so that several blocks can be chained. The half-digit stays set until reset, and the decades go on counting past the rollover.

An active-low inhibit freezes the first decade while it is low. Edges that arrive during that time are lost. An active-low reset returns the counter to zero. The inhibit and reset inputs must be tied high when unused.

Top module: `decade_event_counter`

## Requirements
- R1: A falling edge on `count_i` raises the count by exactly one. The new value shows on `digits_o` after the third rising clock edge following the input change. Digit k (k = 0 is the least significant) sits in bits [4k+3:4k].
- R2: Each decade steps through 0 to 9 and never holds a value above 9. When it steps from 9 to 0 it advances the next decade in the same clock.
- R3: `carry_n_o` rests high. It is low for exactly one clock cycle, in the cycle right after the step that takes the decades from 9999 to 0000.
- R4: `half_o` is set by the step that takes the decades from 9999 to 0000. Only reset clears it. Later rollovers leave it set.
- R5: After `half_o` is set, the decades keep counting normally, and every further rollover produces another carry pulse.
- R6: A step that falls on a clock edge where `inhibit_n_i` is low is discarded. The decades stay unchanged, and the discarded edge is not counted after inhibit is released.
- R7: At any clock edge where `rst_n` is low, the block clears all digits and `half_o`, and drives `carry_n_o` high. This takes priority over a step that falls on the same edge. The synchronizer returns to its idle-high state, so an input held high through reset produces no count.
- R8: Rising edges and steady levels on `count_i` do not change the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of counter and synchronizer |
| count_i | input | 1 | Asynchronous event input; falling edges are counted |
| inhibit_n_i | input | 1 | Active-low freeze of the first decade |
| digits_o | output | 4*NUM_DEC | BCD digits, least significant digit in the low nibble |
| half_o | output | 1 | Overflow half-digit |
| carry_n_o | output | 1 | Active-low one-cycle carry pulse on full rollover |

## Verification
The bench runs the count through two full rollovers, 9999 to 0000. At each one it looks for a single-cycle carry pulse. A design that held the carry low for longer, or pulsed it only on the first rollover, would fail these checks. So would a design that cleared the half-digit on the second wrap.

The bench also sends edges while inhibit is low and then releases inhibit. A design that gated the input instead of the stage, and so counted a stored edge late, would be caught. A reset is placed on the very clock where a step lands. A design that let the step win would be left at a nonzero value. Held levels and rising edges are sent on the input, and they must leave the count untouched.

// File: rtl/dec_cnt_pkg.sv
// Shared constants and types for the decade event counter.
package dec_cnt_pkg;
    localparam int unsigned BCD_W = 4;
    typedef logic [BCD_W-1:0] bcd_t;
    localparam bcd_t BCD_TOP  = 4'd9;
    localparam bcd_t BCD_ZERO = 4'd0;
endpackage

// File: rtl/edge_sync.sv
// Synchronizes an asynchronous input into the clk domain and flags each
// falling edge with a one-cycle pulse.
// Assumes: the input stays at each level for at least two clk cycles.
// After reset every stage reads as high (idle level).
module edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o
);
    // Synchronizer flops plus one history flop for edge detection.
    logic [SYNC_STAGES:0] shreg;

    // Shift the input through the chain; reset loads the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '1;
        else        shreg <= {shreg[SYNC_STAGES-1:0], async_i};
    end

    // A falling edge shows as old-high, new-low at the chain's end.
    always_comb fall_o = shreg[SYNC_STAGES] & ~shreg[SYNC_STAGES-1];
endmodule

// File: rtl/bcd_decade.sv
// One decimal decade: advances on step_i, wraps 9 -> 0, and flags the wrap
// combinationally so the next decade steps in the same cycle.
// Assumes: step_i is a single-cycle enable in the clk domain.
module bcd_decade
    import dec_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    output bcd_t digit_o,
    output logic wrap_o
);
    // Wrap when stepping from the top digit.
    always_comb wrap_o = step_i && (digit_o == BCD_TOP);

    // Digit register: clear on reset, wrap or increment on step.
    always_ff @(posedge clk) begin
        if (!rst_n)      digit_o <= BCD_ZERO;
        else if (wrap_o) digit_o <= BCD_ZERO;
        else if (step_i) digit_o <= digit_o + 1'b1;
    end
endmodule

// File: rtl/overflow_stage.sv
// Turns the top decade's wrap into a sticky half-digit and a one-cycle
// active-low carry pulse.
// Assumes: wrap_i is a single-cycle pulse.
module overflow_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    output logic half_o,
    output logic carry_n_o
);
    // Sticky half-digit; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)      half_o <= 1'b0;
        else if (wrap_i) half_o <= 1'b1;
    end

    // Carry is low for the single cycle after a full rollover.
    always_ff @(posedge clk) begin
        if (!rst_n) carry_n_o <= 1'b1;
        else        carry_n_o <= ~wrap_i;
    end
endmodule

// File: rtl/decade_event_counter.sv
// Top: synchronized falling-edge counter of NUM_DEC BCD decades plus an
// overflow half-digit and a cascade carry.
// Assumes: inhibit_n_i is synchronous to clk; count_i may be asynchronous
// but changes slower than half the clk rate.
module decade_event_counter
    import dec_cnt_pkg::*;
#(
    parameter int unsigned NUM_DEC     = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     count_i,
    input  logic                     inhibit_n_i,
    output logic [NUM_DEC*BCD_W-1:0] digits_o,
    output logic                     half_o,
    output logic                     carry_n_o
);
    localparam int unsigned DW = NUM_DEC * BCD_W;

    logic               fall;
    logic [NUM_DEC:0]   step;
    logic [DW-1:0]      digits;

    edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(count_i),
        .fall_o (fall)
    );

    // Inhibit gates only the first stage's step, not the edge detector.
    always_comb step[0] = fall & inhibit_n_i;

    // Decade chain: each wrap steps the next decade in the same cycle.
    for (genvar k = 0; k < NUM_DEC; k++) begin : g_dec
        bcd_decade u_dec (
            .clk    (clk),
            .rst_n  (rst_n),
            .step_i (step[k]),
            .digit_o(digits[k*BCD_W +: BCD_W]),
            .wrap_o (step[k+1])
        );
    end

    overflow_stage u_ovf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap_i   (step[NUM_DEC]),
        .half_o   (half_o),
        .carry_n_o(carry_n_o)
    );

    // Expose digits.
    always_comb digits_o = digits;
endmodule

// File: rtl/decade_event_counter_chk.sv
// Property checker for decade_event_counter, attached by bind.
module decade_event_counter_chk #(
    parameter int unsigned NUM_DEC = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 inhibit_n_i,
    input logic [NUM_DEC*4-1:0] digits_o,
    input logic                 half_o,
    input logic                 carry_n_o
);
    function automatic logic all_bcd(input logic [NUM_DEC*4-1:0] d);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < NUM_DEC; k++)
            if (d[k*4 +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    AST_DIGITS_BCD: assert property (@(posedge clk) disable iff (!rst_n)
        all_bcd(digits_o)); // R2
    AST_CARRY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n_o |=> carry_n_o); // R3
    AST_CARRY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n_o |-> (digits_o == '0 && half_o)); // R3
    AST_HALF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        half_o |=> half_o); // R4
    AST_INHIBIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit_n_i |=> $stable(digits_o)); // R6
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (digits_o == '0 && !half_o && carry_n_o)); // R7
endmodule

bind decade_event_counter decade_event_counter_chk #(.NUM_DEC(NUM_DEC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .inhibit_n_i(inhibit_n_i),
    .digits_o   (digits_o),
    .half_o     (half_o),
    .carry_n_o  (carry_n_o)
);

// File: tb/decade_event_counter_tb.sv
module decade_event_counter_tb;
    localparam int NUM_DEC = 4;
    localparam int MODULUS = 10000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic count_i = 1'b1;
    logic inhibit_n_i = 1'b1;
    logic [NUM_DEC*4-1:0] digits_o;
    logic half_o, carry_n_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;
    int carry_lows = 0;

    // Reference model state
    int m_count = 0;
    bit m_half = 0;
    bit m_carry_n = 1;
    bit h1 = 1, h2 = 1, h3 = 1;

    always #2.5 clk = ~clk;

    decade_event_counter #(.NUM_DEC(NUM_DEC)) u_dut (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .inhibit_n_i(inhibit_n_i),
        .digits_o(digits_o), .half_o(half_o), .carry_n_o(carry_n_o)
    );

    function automatic logic [NUM_DEC*4-1:0] to_bcd(input int v);
        logic [NUM_DEC*4-1:0] r;
        int x;
        x = v;
        for (int k = 0; k < NUM_DEC; k++) begin
            r[k*4 +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Behavioural model: falling edge seen after the input history delay.
    always @(posedge clk) begin
        bit step;
        cycles++;
        step = h3 && !h2;
        if (!rst_n) begin
            m_count = 0; m_half = 0; m_carry_n = 1;
            h1 = 1; h2 = 1; h3 = 1;
        end else begin
            m_carry_n = 1;
            if (step && inhibit_n_i) begin
                m_count = m_count + 1;
                if (m_count == MODULUS) begin
                    m_count = 0; m_half = 1; m_carry_n = 0;
                end
            end
            h3 = h2; h2 = h1; h1 = count_i;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (cycles > 0 && !done) begin
            check(digits_o == to_bcd(m_count), "R1 digits", int'(digits_o), int'(to_bcd(m_count)));
            check(half_o == m_half, "R4 half", half_o, m_half);
            check(carry_n_o == m_carry_n, "R3 carry", carry_n_o, m_carry_n);
            if (!carry_n_o) carry_lows++;
        end
    end

    task automatic pulse();
        @(negedge clk) count_i = 1'b0;
        @(negedge clk);
        @(negedge clk) count_i = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) pulse();
        repeat (4) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        check(digits_o == '0, "R7 reset digits", int'(digits_o), 0);
        check(half_o == 1'b0, "R7 reset half", half_o, 0);
        check(carry_n_o == 1'b1, "R7 reset carry", carry_n_o, 1);
        @(negedge clk) rst_n = 1'b1;

        // R1/R2: basic counting across a decade wrap
        pulses(25);
        check(digits_o == to_bcd(25), "R2 count 25", int'(digits_o), int'(to_bcd(25)));

        // R8: held low, rising edge and held high give no count
        @(negedge clk) count_i = 1'b0;
        repeat (8) @(negedge clk);
        check(digits_o == to_bcd(26), "R8 one count for held low", int'(digits_o), int'(to_bcd(26)));
        count_i = 1'b1;
        repeat (8) @(negedge clk);
        check(digits_o == to_bcd(26), "R8 rising edge ignored", int'(digits_o), int'(to_bcd(26)));

        // R6: edges during inhibit are lost
        @(negedge clk) inhibit_n_i = 1'b0;
        pulses(3);
        check(digits_o == to_bcd(26), "R6 inhibited", int'(digits_o), int'(to_bcd(26)));
        @(negedge clk) inhibit_n_i = 1'b1;
        repeat (6) @(negedge clk);
        check(digits_o == to_bcd(26), "R6 no late count", int'(digits_o), int'(to_bcd(26)));

        // R3/R4: first rollover
        pulses(9999 - 26);
        check(digits_o == to_bcd(9999), "R2 at 9999", int'(digits_o), int'(to_bcd(9999)));
        carry_lows = 0;
        pulses(1);
        check(digits_o == '0, "R3 wrap digits", int'(digits_o), 0);
        check(half_o == 1'b1, "R4 half set", half_o, 1);
        check(carry_lows == 1, "R3 single carry cycle", carry_lows, 1);

        // R5: keep counting, second rollover
        pulses(7);
        check(digits_o == to_bcd(7), "R5 counts after half", int'(digits_o), int'(to_bcd(7)));
        carry_lows = 0;
        pulses(MODULUS - 7);
        check(carry_lows == 1, "R5 second carry", carry_lows, 1);
        check(half_o == 1'b1, "R4 half stays", half_o, 1);
        check(digits_o == '0, "R5 second wrap", int'(digits_o), 0);

        // R7: reset wins over a coincident step
        pulses(5);
        @(negedge clk) count_i = 1'b0;
        @(negedge clk);
        @(negedge clk) begin rst_n = 1'b0; count_i = 1'b1; end
        @(negedge clk) rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(digits_o == '0, "R7 reset priority", int'(digits_o), 0);
        check(half_o == 1'b0, "R7 half cleared", half_o, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule